// File: doc/BRIEF.md
# Daisy-Chain Host Reader

This block sits on the host side of a serial link to a chain of identical 24-bit converters. The devices are wired one after another, and all of them share one serial clock and one select line. When the device nearest the host pulls its data-ready line low, the reader opens a burst. It can drop a shared active-low select for the burst. It toggles the serial clock exactly as often as the whole chain needs, and it shifts in one data bit on every falling edge of that clock.

When the burst completes, the reader splits the collected stream into one word per device. The device wired to the host comes first, and each word is sign-extended from 24 to 32 bits. A one-cycle strobe marks the new words. If data-ready rises before the burst is finished, the partial frame is dropped and a sticky error flag is raised. The chain length, the serial clock half-period in system clocks, and whether the select line is driven are all parameters.

Top module: `chain_reader`

## Requirements
- R1: During one completed frame the reader produces exactly 24×CHAIN_LEN falling edges on `sclk`. At each falling edge it captures the `sdo` value that was present just before that edge.
- R2: In `wordsOut`, slot i occupies bits [32i+31:32i]. Slot 0 holds the first 24 bits received, slot 1 the next 24, and so on. Each word is assembled MSB first.
- R3: Bit 23 of each 24-bit word is replicated into bits 31 to 24 of its 32-bit slot.
- R4: After reset: `sclk` is 1, `csN` is 1 (when the select is used), `wordsValid` is 0, `overrun` is 0 and `wordsOut` is 0. A frame starts only on a clock where `drdyN` is sampled 0 after it was sampled 1 on the clock before.
- R5: `sclk` idles high. Once a frame starts, `sclk` stays high for HALF_DIV clocks, then alternates low and high for HALF_DIV clocks each. After the last bit it ends high.
- R6: With USE_CS=1, `csN` is 0 from the start clock until the frame ends. With USE_CS=0, `csN` is 0 at all times.
- R7: `wordsValid` pulses for one clock, on the clock where `sclk` returns high after the final bit. `wordsOut` changes only on that clock.
- R8: If `drdyN` is sampled 1 before all 24×CHAIN_LEN bits are captured, the frame is abandoned: `overrun` is set and stays set until reset, `wordsValid` does not pulse, and `wordsOut` keeps its previous value.
- R9: If `drdyN` rises after the last bit was captured but before the closing `sclk` rise, the frame still completes normally.
- R10: At most one frame is read per data-ready low period. After a frame completes, the reader stays idle while `drdyN` remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| drdyN | input | 1 | Active-low data-ready from the nearest device |
| sdo | input | 1 | Serial data from the nearest device |
| sclk | output | 1 | Serial clock to all devices, idles high |
| csN | output | 1 | Shared active-low select |
| wordsOut | output | 32×CHAIN_LEN | Sign-extended result words, slot 0 nearest device |
| wordsValid | output | 1 | One-cycle strobe for new words |
| overrun | output | 1 | Sticky flag for a frame cut short by data-ready |

## Verification
The assertions assume that `drdyN` and `sdo` are already synchronous to `clk` and that `sdo` changes only after a falling edge of `sclk`, never on the same clock edge that samples it. The bench enforces this by changing `drdyN` only on falling `clk` edges. Its model of the converter chain advances `sdo` one time unit after each falling edge of `sclk`. Data-ready windows are chosen on both sides of the minimum window, so that cutting a frame one clock short and rising just after the last capture are both exercised.

// File: rtl/chain_reader_pkg.sv
package chain_reader_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 32;

  typedef struct packed {
    logic start;   // clear the shift register for a new frame
    logic sample;  // capture sdo on this sclk fall
    logic load;    // publish the assembled words
  } rdStrobe_t;
endpackage

// File: rtl/chain_reader_ctrl.sv
module chain_reader_ctrl
  import chain_reader_pkg::*;
#(
  parameter int TOTAL_BITS = 48,
  parameter int HALF_DIV   = 2,
  parameter bit USE_CS     = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       drdyN,
  output logic       sclk,
  output logic       csN,
  output logic       wordsValid,
  output logic       overrun,
  output rdStrobe_t  strobe
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(TOTAL_BITS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(TOTAL_BITS);

  typedef enum logic {ST_IDLE, ST_SHIFT} state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             drdyPrev;
  logic             startHit, abortHit, halfDone, finishHit;

  always_comb begin
    startHit  = (state == ST_IDLE) && drdyPrev && !drdyN;
    halfDone  = (divCnt == DIV_LAST);
    abortHit  = (state == ST_SHIFT) && drdyN && (bitCnt < BIT_LAST);
    finishHit = (state == ST_SHIFT) && !abortHit && halfDone && !sclk &&
                (bitCnt == BIT_LAST);
    strobe        = '0;
    strobe.start  = startHit;
    strobe.sample = (state == ST_SHIFT) && !abortHit && halfDone && sclk;
    strobe.load   = finishHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      divCnt     <= '0;
      bitCnt     <= '0;
      sclk       <= 1'b1;
      drdyPrev   <= 1'b1;
      wordsValid <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      drdyPrev   <= drdyN;
      wordsValid <= finishHit;
      if (startHit) begin
        state  <= ST_SHIFT;
        divCnt <= '0;
        bitCnt <= '0;
        sclk   <= 1'b1;
      end else if (abortHit) begin
        state   <= ST_IDLE;
        overrun <= 1'b1;
        sclk    <= 1'b1;
      end else if (state == ST_SHIFT) begin
        if (halfDone) begin
          divCnt <= '0;
          sclk   <= !sclk;
          if (sclk) bitCnt <= bitCnt + 1'b1;
          if (finishHit) state <= ST_IDLE;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  generate
    if (USE_CS) begin : g_cs
      assign csN = (state != ST_SHIFT);
    end else begin : g_nocs
      assign csN = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/chain_reader_datapath.sv
module chain_reader_datapath
  import chain_reader_pkg::*;
#(
  parameter int CHAIN_LEN = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sdo,
  input  rdStrobe_t                   strobe,
  output logic [CHAIN_LEN*SLOT_W-1:0] wordsOut
);
  localparam int TOTAL_BITS = SAMPLE_W * CHAIN_LEN;

  logic [TOTAL_BITS-1:0]           shiftReg;
  logic [CHAIN_LEN*SLOT_W-1:0]     slotNext;

  always_ff @(posedge clk) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobe.start)  shiftReg <= '0;
    else if (strobe.sample) shiftReg <= {shiftReg[TOTAL_BITS-2:0], sdo};
  end

  genvar gi;
  generate
    for (gi = 0; gi < CHAIN_LEN; gi++) begin : g_slot
      localparam int TOP = TOTAL_BITS - 1 - gi * SAMPLE_W;
      assign slotNext[gi*SLOT_W +: SLOT_W] =
        {{(SLOT_W-SAMPLE_W){shiftReg[TOP]}}, shiftReg[TOP -: SAMPLE_W]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            wordsOut <= '0;
    else if (strobe.load) wordsOut <= slotNext;
  end
endmodule

// File: rtl/chain_reader.sv
module chain_reader
  import chain_reader_pkg::*;
#(
  parameter int CHAIN_LEN = 2,
  parameter int HALF_DIV  = 2,
  parameter bit USE_CS    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        drdyN,
  input  logic                        sdo,
  output logic                        sclk,
  output logic                        csN,
  output logic [CHAIN_LEN*SLOT_W-1:0] wordsOut,
  output logic                        wordsValid,
  output logic                        overrun
);
  localparam int TOTAL_BITS = SAMPLE_W * CHAIN_LEN;

  rdStrobe_t strobe;

  chain_reader_ctrl #(
    .TOTAL_BITS(TOTAL_BITS),
    .HALF_DIV  (HALF_DIV),
    .USE_CS    (USE_CS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .drdyN     (drdyN),
    .sclk      (sclk),
    .csN       (csN),
    .wordsValid(wordsValid),
    .overrun   (overrun),
    .strobe    (strobe)
  );

  chain_reader_datapath #(
    .CHAIN_LEN(CHAIN_LEN)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .sdo     (sdo),
    .strobe  (strobe),
    .wordsOut(wordsOut)
  );
endmodule

// File: rtl/chain_reader_chk.sv
module chain_reader_chk #(
  parameter int CHAIN_LEN = 2,
  parameter bit USE_CS    = 1'b1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    sclk,
  input logic                    csN,
  input logic [CHAIN_LEN*32-1:0] wordsOut,
  input logic                    wordsValid,
  input logic                    overrun
);
  // R8: the error flag never clears without reset
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R7: the strobe lasts a single clock
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordsValid |=> !wordsValid);

  // R7: results change only together with the strobe
  assert_words_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wordsValid |-> $stable(wordsOut));

  // R5: a frame ends with the serial clock back high
  assert_ends_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    wordsValid |-> sclk);

  // R8: an abandoned frame never publishes
  assert_abort_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> !wordsValid);

  generate
    if (USE_CS) begin : g_cs
      // R6: serial clock is only driven low while the chain is selected
      assert_low_inside_select_R6: assert property (@(posedge clk) disable iff (!rstN)
        !sclk |-> !csN);
    end
  endgenerate
endmodule

bind chain_reader chain_reader_chk #(
  .CHAIN_LEN(CHAIN_LEN),
  .USE_CS   (USE_CS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclk      (sclk),
  .csN       (csN),
  .wordsOut  (wordsOut),
  .wordsValid(wordsValid),
  .overrun   (overrun)
);

// File: tb/chain_reader_tb.sv
module chain_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K     = 2;
  localparam int HALF  = 2;
  localparam int TOTAL = 24 * K;
  localparam int FRAME = 2 * HALF * TOTAL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic drdyN = 1'b1;
  logic sdo;
  logic sclk, csN, wordsValid, overrun;
  logic sclk2, csN2, wordsValid2, overrun2;
  logic [K*32-1:0] wordsOut, wordsOut2;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_reader #(.CHAIN_LEN(K), .HALF_DIV(HALF), .USE_CS(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .drdyN(drdyN), .sdo(sdo), .sclk(sclk), .csN(csN),
    .wordsOut(wordsOut), .wordsValid(wordsValid), .overrun(overrun));

  chain_reader #(.CHAIN_LEN(K), .HALF_DIV(HALF), .USE_CS(1'b0)) u_dutNoCs (
    .clk(clk), .rstN(rstN), .drdyN(drdyN), .sdo(sdo), .sclk(sclk2), .csN(csN2),
    .wordsOut(wordsOut2), .wordsValid(wordsValid2), .overrun(overrun2));

  // Converter chain model: the stream shifts one bit after each sclk fall
  logic [TOTAL-1:0] stream = '0;
  int fallIdx = TOTAL;
  always @(negedge sclk) begin
    #1;
    fallIdx = fallIdx + 1;
  end
  assign sdo = (fallIdx < TOTAL) ? stream[TOTAL-1-fallIdx] : 1'b0;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R4 reset";

  // Behavioural reference, advanced on every rising clock
  bit mPrev = 1'b1, mBusy = 1'b0, mOver = 1'b0, expSclk = 1'b1, expValid = 1'b0;
  int mJ = 0;
  logic [K*32-1:0] expWords = '0;

  function automatic logic [K*32-1:0] slotsFrom(input logic [TOTAL-1:0] s);
    logic [K*32-1:0] r;
    for (int i = 0; i < K; i++) begin
      logic [23:0] w;
      w = s[TOTAL-1-24*i -: 24];
      r[32*i +: 32] = {{8{w[23]}}, w};
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 1'b1; mBusy = 1'b0; mOver = 1'b0; expSclk = 1'b1;
      expValid = 1'b0; expWords = '0; mJ = 0;
    end else begin
      expValid = 1'b0;
      if (!mBusy) begin
        if (mPrev && !drdyN) begin
          mBusy = 1'b1; mJ = 0; expSclk = 1'b1;
        end
      end else begin
        int taken;
        mJ = mJ + 1;
        taken = (mJ <= HALF) ? 0 : ((mJ - HALF - 1) / (2 * HALF)) + 1;
        if (taken > TOTAL) taken = TOTAL;
        if (drdyN && taken < TOTAL) begin
          mBusy = 1'b0; mOver = 1'b1; expSclk = 1'b1;
        end else if (mJ == FRAME) begin
          mBusy = 1'b0; expSclk = 1'b1; expValid = 1'b1;
          expWords = slotsFrom(stream);
        end else begin
          expSclk = ((mJ / HALF) % 2) == 0;
        end
      end
      mPrev = drdyN;
    end
  end

  task automatic chk(input string what, input logic [K*32-1:0] act,
                     input logic [K*32-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s] actual %h expected %h", what, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R5 sclk", {{(K*32-1){1'b0}}, sclk}, {{(K*32-1){1'b0}}, expSclk});
    chk("R6 csN select", {{(K*32-1){1'b0}}, csN}, {{(K*32-1){1'b0}}, !mBusy});
    chk("R6 csN tied low", {{(K*32-1){1'b0}}, csN2}, '0);
    chk("R5 sclk no-select", {{(K*32-1){1'b0}}, sclk2}, {{(K*32-1){1'b0}}, expSclk});
    chk("R7 valid", {{(K*32-1){1'b0}}, wordsValid}, {{(K*32-1){1'b0}}, expValid});
    chk("R8 overrun", {{(K*32-1){1'b0}}, overrun}, {{(K*32-1){1'b0}}, mOver});
    chk("R2 R3 words", wordsOut, expWords);
    chk("R2 R3 words no-select", wordsOut2, expWords);
    if (expValid)
      chk("R1 fall count", K*32'(fallIdx), K*32'(TOTAL));
  end

  task automatic runFrame(input logic [TOTAL-1:0] bits, input int lowCycles,
                          input int highCycles, input string tag);
    @(negedge clk);
    phase = tag;
    stream = bits;
    fallIdx = 0;
    drdyN = 1'b0;
    repeat (lowCycles) @(negedge clk);
    drdyN = 1'b1;
    repeat (highCycles) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog [%s] actual hung expected finished", phase);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);            // R4 reset values compared each clock
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    runFrame({24'h800001, 24'h123456}, FRAME + 20, 10, "R1 R2 R3 mixed signs");
    runFrame({24'h7FFFFF, 24'hFFFFFF}, FRAME + 20, 10, "R3 extremes");
    runFrame({24'hA5A5A5, 24'h00FF00}, FRAME + 20, 10, "R2 slot order");
    runFrame({24'h111111, 24'h222222}, FRAME - HALF, 10, "R8 one clock short");
    runFrame({24'hC00003, 24'h3FFFFC}, FRAME - HALF + 1, 10, "R9 late rise");
    runFrame({24'h0F0F0F, 24'hF0F0F0}, FRAME + 100, 10, "R10 long low");
    runFrame({24'h000000, 24'h800000}, 30, 10, "R8 early abort");
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule